// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock of an I2C controller from the reference clock. It has two programmable pairs of period counts: one pair for standard speed and one for fast speed. A speed field in a small control register picks the pair in use. While running, the block holds SCL low for a counted low phase. It then lets the line go and counts the high phase. The high count only advances while the line reads back high, so a target that holds SCL low stretches the period without any extra logic in the bus engine.

The block gives the bus engine two strobes. The first marks the first cycle of every low phase, where SDA may change. The second marks the middle of every high phase, where SDA is sampled. Before the first low phase after enabling, SCL stays released for a start-hold interval. This gives the bus engine room to form a start condition on SDA. The period counts carry fixed overheads, so the low phase is one cycle longer than its count and the high phase is eight cycles longer than its count.

Configuration is written through a simple write port. It is accepted only while the run input is low, so the timing of a running bus can never change halfway through a bit.

Top module: `scl_period_gen`

## Requirements
- R1: While running and with no stretching, each low phase (`scl_low_o` high) lasts exactly the selected low count plus 1 cycles.
- R2: With no stretching, each released interval between two low phases lasts exactly the selected high count plus 8 cycles.
- R3: If the line reads low for S cycles after the block releases it, the released interval lasts the high count plus 8 plus S cycles, and the sample strobe moves later by S cycles.
- R4: The first low phase begins the high count plus 3 cycles after the first clock edge that samples the run condition true. Counting the cycle in which `en_i` is first seen high, SCL stays released for the high count plus 4 cycles.
- R5: Control bits [2:1] select the pair. The value 2'b10 (control word 0x4) selects the fast pair at addresses 3 (high) and 4 (low). Any other value, including 2'b01 (0x2) and 2'b11, selects the standard pair at addresses 1 (high) and 2 (low).
- R6: Control bit 0 enables the controller. While this bit is 0, `en_i` has no effect: SCL stays released and neither strobe fires.
- R7: Writes (address 0 control, 1 to 4 period counts) while `en_i` is high are ignored, and the earlier values stay in force after the block is disabled and enabled again.
- R8: `sample_stb_o` is a one-cycle pulse, never during a low phase. With no stretching it falls on released cycle 2 + floor((high count + 6) / 2), counting the first released cycle as 0.
- R9: `low_stb_o` is high exactly in the first cycle of each low phase.
- R10: One cycle after the edge that samples `en_i` low, SCL is released and both strobes are low. The next enable starts again with the start-hold interval.
- R11: After reset, SCL is released, both strobes are low and all registers are zero, so raising `en_i` before any programming leaves SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run request; also blocks configuration writes while high |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Write address: 0 control, 1 std high, 2 std low, 3 fast high, 4 fast low |
| wr_data_i | input | CNT_W | Write data |
| scl_in_i | input | 1 | SCL level read back from the pad (asynchronous) |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| low_stb_o | output | 1 | Pulse on the first cycle of each low phase |
| sample_stb_o | output | 1 | Pulse at the middle of each high phase |

## Verification
The period is measured with the standard pair, with the fast pair and with speed code 2'b11. The three cases tell a correct pair decode from a decode that looks at only one speed bit. The target-stretch pattern holds the line low after each release, which separates a high count that waits for the line from one that free-runs after release. A run during which the configuration is rewritten, followed by a clean restart, separates a write port that is truly blocked from one that lets writes through. Enabling with the controller bit clear, and enabling right after reset, shows the gating on the enable bit.

// File: rtl/scl_gen_pkg.sv
// Shared constants and types for the SCL period generator.
// Assumes register addresses are 3 bits wide and the control word uses bits [2:0].
package scl_gen_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    // pair p uses ADR_PAIR_BASE + 2p (high) and ADR_PAIR_BASE + 2p + 1 (low)
    localparam int ADR_PAIR_BASE = 1;
    localparam int NUM_PAIRS     = 2;
    localparam int PAIR_STD      = 0;
    localparam int PAIR_FAST     = 1;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_SPEED_LSB = 1;
    localparam logic [1:0] SPEED_FAST_CODE = 2'b10;

    // fixed overheads added to the programmed counts
    localparam int HIGH_OVERHEAD = 8;
    localparam int HOLD_OVERHEAD = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_SETTLE,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic       run_en;
        logic [1:0] speed;
    } ctrl_t;

endpackage

// File: rtl/scl_cfg_regs.sv
// Configuration registers: control word and one high/low count pair per speed.
// Writes are taken only while the block is not enabled.
// Assumes CNT_W >= 3 so the control fields fit in the write data.
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lock_i,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [CNT_W-1:0]                  wr_data_i,
    output ctrl_t                             ctrl_o,
    output logic [NUM_PAIRS-1:0][CNT_W-1:0]   hi_cnt_o,
    output logic [NUM_PAIRS-1:0][CNT_W-1:0]   lo_cnt_o
);

    logic wr_ok;

    // a write is accepted only while the generator is stopped
    assign wr_ok = wr_en_i && !lock_i;

    // control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (wr_ok && wr_addr_i == ADR_CTRL) begin
            ctrl_o.run_en <= wr_data_i[CTRL_EN_BIT];
            ctrl_o.speed  <= wr_data_i[CTRL_SPEED_LSB +: 2];
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam logic [ADDR_W-1:0] HI_ADR = ADDR_W'(ADR_PAIR_BASE + 2 * p);
        localparam logic [ADDR_W-1:0] LO_ADR = ADDR_W'(ADR_PAIR_BASE + 2 * p + 1);

        // high count of this pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_cnt_o[p] <= '0;
            end else if (wr_ok && wr_addr_i == HI_ADR) begin
                hi_cnt_o[p] <= wr_data_i;
            end
        end

        // low count of this pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_cnt_o[p] <= '0;
            end else if (wr_ok && wr_addr_i == LO_ADR) begin
                lo_cnt_o[p] <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/scl_line_sync.sv
// Brings the asynchronous SCL read-back into the clock domain.
// Resets to 1 (released bus). The latency is STAGES cycles.
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    if (STAGES <= 1) begin : g_single
        logic q;
        // single sampling flop
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b1;
            else        q <= line_i;
        end
        assign line_o = q;
    end else begin : g_chain
        logic [STAGES-1:0] sr;
        // shift chain of STAGES flops
        always_ff @(posedge clk) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2:0], line_i};
        end
        assign line_o = sr[STAGES-1];
    end

endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencer: start hold, counted low phase, synchronizer settle,
// then a high phase that only counts while the synced line is high.
// Assumes hi_i/lo_i are stable while active_i is high and SYNC_STAGES is
// smaller than the fixed high overhead.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             line_high_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic             scl_low_o,
    output logic             low_stb_o,
    output logic             sample_stb_o
);

    localparam int CW         = CNT_W + 1;
    localparam int HIGH_TAIL  = HIGH_OVERHEAD - SYNC_STAGES - 1;
    localparam int HIGH_SPAN  = HIGH_OVERHEAD - SYNC_STAGES;
    localparam logic [CW-1:0] SETTLE_END = CW'(SYNC_STAGES - 1);

    phase_e          phase;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   hold_end;
    logic [CW-1:0]   low_end;
    logic [CW-1:0]   high_end;
    logic [CW-1:0]   high_mid;
    logic [CW-1:0]   cnt_inc;

    // terminal and midpoint values derived from the selected counts
    always_comb begin
        hold_end = {1'b0, hi_i} + CW'(HOLD_OVERHEAD - 1);
        low_end  = {1'b0, lo_i};
        high_end = {1'b0, hi_i} + CW'(HIGH_TAIL);
        high_mid = ({1'b0, hi_i} + CW'(HIGH_SPAN)) >> 1;
        cnt_inc  = cnt + CW'(1);
    end

    // phase sequencing and the shared phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (!active_i) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_HOLD;
                    cnt   <= '0;
                end
                PH_HOLD: begin
                    if (cnt == hold_end) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                PH_LOW: begin
                    if (cnt == low_end) begin
                        phase <= PH_SETTLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                PH_SETTLE: begin
                    if (cnt == SETTLE_END) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                PH_HIGH: begin
                    if (line_high_i) begin
                        if (cnt == high_end) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt_inc;
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // line drive and bit-phase strobes decoded from the phase state
    always_comb begin
        scl_low_o    = (phase == PH_LOW);
        low_stb_o    = (phase == PH_LOW) && (cnt == '0);
        sample_stb_o = (phase == PH_HIGH) && line_high_i && (cnt == high_mid);
    end

endmodule

// File: rtl/scl_period_gen.sv
// SCL period generator top: configuration registers, pair selection,
// read-back synchronizer and the phase sequencer.
// Assumes scl_in_i is the open-drain line level, including the block's own pull-down.
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             scl_in_i,
    output logic             scl_low_o,
    output logic             low_stb_o,
    output logic             sample_stb_o
);

    ctrl_t                            ctrl;
    logic [NUM_PAIRS-1:0][CNT_W-1:0]  hi_cnt;
    logic [NUM_PAIRS-1:0][CNT_W-1:0]  lo_cnt;
    logic [CNT_W-1:0]                 sel_hi;
    logic [CNT_W-1:0]                 sel_lo;
    logic                             fast_sel;
    logic                             active;
    logic                             line_high;

    scl_cfg_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (en_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl),
        .hi_cnt_o  (hi_cnt),
        .lo_cnt_o  (lo_cnt)
    );

    // pair selection and run qualification
    always_comb begin
        fast_sel = (ctrl.speed == SPEED_FAST_CODE);
        sel_hi   = fast_sel ? hi_cnt[PAIR_FAST] : hi_cnt[PAIR_STD];
        sel_lo   = fast_sel ? lo_cnt[PAIR_FAST] : lo_cnt[PAIR_STD];
        active   = en_i && ctrl.run_en;
    end

    scl_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_in_i),
        .line_o (line_high)
    );

    scl_phase_fsm #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (active),
        .line_high_i  (line_high),
        .hi_i         (sel_hi),
        .lo_i         (sel_lo),
        .scl_low_o    (scl_low_o),
        .low_stb_o    (low_stb_o),
        .sample_stb_o (sample_stb_o)
    );

endmodule

// File: rtl/scl_period_gen_chk.sv
// Property checker for scl_period_gen, attached through bind.
// Measures the low phase with its own counter and checks strobe shapes.
module scl_period_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             scl_low_o,
    input logic             low_stb_o,
    input logic             sample_stb_o,
    input logic [CNT_W-1:0] sel_lo
);

    logic [CNT_W+1:0] lo_run;

    // length of the current run of low cycles
    always_ff @(posedge clk) begin
        if (!rst_n)         lo_run <= '0;
        else if (scl_low_o) lo_run <= lo_run + 1'b1;
        else                lo_run <= '0;
    end

    AST_LOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_low_o) && $past(en_i)) |-> (lo_run == {2'b00, sel_lo} + 1'b1)); // R1

    AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> !scl_low_o); // R8

    AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |=> !sample_stb_o); // R8

    AST_LOW_STB_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        low_stb_o |-> $rose(scl_low_o)); // R9

    AST_FALL_HAS_LOW_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_o) |-> low_stb_o); // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!scl_low_o && !low_stb_o && !sample_stb_o)); // R10

endmodule

bind scl_period_gen scl_period_gen_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .scl_low_o    (scl_low_o),
    .low_stb_o    (low_stb_o),
    .sample_stb_o (sample_stb_o),
    .sel_lo       (sel_lo)
);

// File: tb/scl_period_gen_test.sv
// Scoreboard bench: the driver queues expected phase lengths and strobe
// positions; a negedge monitor measures them and pops to compare.
module scl_period_gen_test;

    localparam int CNT_W = 16;
    localparam int K_HOLD = 0;
    localparam int K_LOW  = 1;
    localparam int K_STB  = 2;
    localparam int K_HIGH = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic             wr_en;
    logic [2:0]       wr_addr;
    logic [CNT_W-1:0] wr_data;
    logic             scl_in;
    logic             scl_low_o;
    logic             low_stb_o;
    logic             sample_stb_o;

    int checks = 0;
    int errors = 0;
    int stretch = 0;
    int rel_cnt = 0;

    int    kq[$];
    int    vq[$];
    string rq[$];

    always #10 clk = ~clk;

    scl_period_gen #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (2)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .scl_in_i     (scl_in),
        .scl_low_o    (scl_low_o),
        .low_stb_o    (low_stb_o),
        .sample_stb_o (sample_stb_o)
    );

    // target model: holds the line low for `stretch` cycles after each release
    always @(posedge clk) begin
        if (scl_low_o)          rel_cnt <= 0;
        else if (rel_cnt < 1000) rel_cnt <= rel_cnt + 1;
    end
    assign scl_in = !scl_low_o && (rel_cnt >= stretch);

    function automatic string kname(input int k);
        case (k)
            K_HOLD:  return "hold";
            K_LOW:   return "low";
            K_STB:   return "sample";
            default: return "high";
        endcase
    endfunction

    task automatic pop_cmp(input int kind, input int val);
        checks++;
        if (kq.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected %s event: actual %0d, expected no event", kname(kind), val);
        end else begin
            int    ek = kq.pop_front();
            int    ev = vq.pop_front();
            string er = rq.pop_front();
            if (ek != kind || ev != val) begin
                errors++;
                $display("FAIL %s %s: actual %s=%0d, expected %s=%0d",
                         er, kname(ek), kname(kind), val, kname(ek), ev);
            end
        end
    endtask

    // monitor: measures released and low runs, strobe positions
    bit mon_first = 1'b1;
    bit prev_low  = 1'b0;
    int run       = 0;
    always @(negedge clk) begin
        if (!rst_n || !en) begin
            mon_first = 1'b1;
            prev_low  = 1'b0;
            run       = 0;
        end else begin
            if (scl_low_o) begin
                if (!prev_low) begin
                    pop_cmp(mon_first ? K_HOLD : K_HIGH, run);
                    mon_first = 1'b0;
                    checks++;
                    if (!low_stb_o) begin
                        errors++;
                        $display("FAIL R9 low strobe at low start: actual 0, expected 1");
                    end
                    run = 1;
                end else begin
                    run++;
                    if (low_stb_o) begin
                        checks++;
                        errors++;
                        $display("FAIL R9 low strobe inside low phase: actual 1, expected 0");
                    end
                end
            end else begin
                if (prev_low) begin
                    pop_cmp(K_LOW, run);
                    run = 1;
                end else begin
                    run++;
                end
                if (sample_stb_o) pop_cmp(K_STB, run - 1);
            end
            prev_low = scl_low_o;
        end
    end

    task automatic push(input int k, input int v, input string r);
        kq.push_back(k);
        vq.push_back(v);
        rq.push_back(r);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(posedge clk); #2;
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d[CNT_W-1:0];
        @(posedge clk); #2;
        wr_en   = 1'b0;
    endtask

    // expected events for n full periods with the given counts
    task automatic push_case(input int hi, input int lo, input int s, input int n,
                             input string tlo, input string thi, input string tstb);
        push(K_HOLD, hi + 4, "R4");
        for (int i = 0; i < n; i++) begin
            push(K_LOW, lo + 1, tlo);
            push(K_STB, 2 + ((hi + 6) / 2) + s, tstb);
            push(K_HIGH, hi + 8 + s, thi);
        end
    endtask

    task automatic start_run(input int s);
        stretch = s;
        @(posedge clk); #2;
        en = 1'b1;
    endtask

    task automatic stop_run();
        int guard = 0;
        while (kq.size() != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk); #2;
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (scl_low_o || low_stb_o || sample_stb_o) begin
            errors++;
            $display("FAIL R10 after stop: actual low=%0b lstb=%0b sstb=%0b, expected 0 0 0",
                     scl_low_o, low_stb_o, sample_stb_o);
        end
        repeat (3) @(posedge clk);
        checks++;
        if (kq.size() != 0) begin
            errors++;
            $display("FAIL R1 missing phases: actual %0d left, expected 0", kq.size());
            kq.delete(); vq.delete(); rq.delete();
        end
    endtask

    // enable for a while and expect the line to stay released with no strobes
    task automatic expect_quiet(input string tag);
        int bad = 0;
        @(posedge clk); #2;
        en = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (scl_low_o || low_stb_o || sample_stb_o) bad++;
        end
        @(posedge clk); #2;
        en = 1'b0;
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s quiet run: actual %0d active cycles, expected 0", tag, bad);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_sim();
    end

    initial begin
        rst_n   = 1'b0;
        en      = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (scl_low_o || low_stb_o || sample_stb_o) begin
            errors++;
            $display("FAIL R11 reset outputs: actual %0b%0b%0b, expected 000",
                     scl_low_o, low_stb_o, sample_stb_o);
        end
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R11: unprogrammed block stays released when enabled
        expect_quiet("R11");

        wr(3'd1, 20); wr(3'd2, 25); wr(3'd3, 6); wr(3'd4, 9);

        // R6: speed set but controller bit clear
        wr(3'd0, 4);
        expect_quiet("R6");

        // R1 R2 R8: standard pair, control 0x3
        wr(3'd0, 3);
        push_case(20, 25, 0, 3, "R1", "R2", "R8");
        start_run(0);
        stop_run();

        // R5: fast pair, control 0x5
        wr(3'd0, 5);
        push_case(6, 9, 0, 3, "R5", "R5", "R8");
        start_run(0);
        stop_run();

        // R5: speed code 2'b11 falls back to standard
        wr(3'd0, 7);
        push_case(20, 25, 0, 2, "R5", "R5", "R5");
        start_run(0);
        stop_run();

        // R3: target stretches every high phase by 5 cycles
        wr(3'd0, 5);
        push_case(6, 9, 5, 3, "R1", "R3", "R3");
        start_run(5);
        stop_run();

        // R7: writes during a run are ignored, and remain ignored afterwards
        push_case(6, 9, 0, 2, "R7", "R7", "R7");
        start_run(0);
        wr(3'd0, 3);
        wr(3'd3, 30);
        wr(3'd4, 40);
        stop_run();
        push_case(6, 9, 0, 2, "R7", "R7", "R7");
        start_run(0);
        stop_run();

        finish_sim();
    end

endmodule